// File: doc/BRIEF.md
# Host/Processor Descriptor Queue Unit

This block moves 32-bit message-frame pointers between a host and an embedded I/O processor through five descriptor queues. The queues hold pointers only, never frame data. New work reaches the processor through a request queue and a high-priority post queue. Completions return to the host through a reply post queue. The free-pointer supply runs in both directions: the host returns reply frames through a reply free queue, and the processor offers high-priority frames through a high-priority free queue.

Each side reaches the queues through a small register window selected by a two-bit address. On the host side, a write pushes a descriptor and a read pops one. The high-priority address pops a free descriptor when the host reads it and accepts a posted descriptor when the host writes it. The processor side mirrors this and serves the opposite end of every queue. All five queues share one single-port storage array. Each queue owns a region of that array, with its own read pointer, write pointer and occupancy count. Only one access reaches the array per cycle, and the host always wins a collision.

Top module: `msgq_unit`

## Requirements
- R1: After reset all queues are empty, `irq_host`, `irq_proc`, `align_err`, `ovf_flags`, `h_rvalid` and `p_rvalid` are 0, and `h_ready` is 1.
- R2: A host write to select 0 pushes `h_wdata` onto the request queue. A processor read of select 0 pops the oldest entry. Read data appears with `p_rvalid`/`h_rvalid` in the cycle after the accepted read.
- R3: A processor write to select 1 pushes onto the reply post queue, and a host read of select 1 pops it. A host write to select 1 pushes onto the reply free queue, and a processor read of select 1 pops it. Every queue is first-in first-out.
- R4: A processor write to select 2 pushes onto the high-priority free queue, and a host read of select 2 pops it. A host write to select 2 pushes onto the high-priority post queue, and a processor read of select 2 pops it.
- R5: A read that finds its queue empty, or that targets a select with no read function (host select 0 or 3, processor select 3), returns 0xFFFFFFFF and removes nothing.
- R6: A host write to select 0 or select 2 whose low 7 bits are not all zero is not stored. It sets the sticky `align_err` output, which only reset clears.
- R7: A push to a full queue (DEPTH entries) is dropped and sets a sticky bit of `ovf_flags`. Bit 0 is the request queue, bit 1 reply post, bit 2 reply free, bit 3 high-priority free and bit 4 high-priority post.
- R8: `p_ready` is the inverse of `h_valid`. A processor access presented while the host is active is not performed and gives no response.
- R9: `irq_proc` is 1 exactly while the request queue or the high-priority post queue holds an entry. `irq_host` is 1 exactly while the reply post queue holds an entry.
- R10: Writes to a select with no write function (processor select 0, select 3 on either side) change no queue and no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| h_valid | input | 1 | Host access strobe |
| h_write | input | 1 | Host access is a write |
| h_sel | input | 2 | Host register select |
| h_wdata | input | DW | Host write descriptor |
| h_ready | output | 1 | Host access accepted (always 1) |
| h_rvalid | output | 1 | Host read data valid |
| h_rdata | output | DW | Host read descriptor or empty marker |
| p_valid | input | 1 | Processor access strobe |
| p_write | input | 1 | Processor access is a write |
| p_sel | input | 2 | Processor register select |
| p_wdata | input | DW | Processor write descriptor |
| p_ready | output | 1 | Processor access accepted |
| p_rvalid | output | 1 | Processor read data valid |
| p_rdata | output | DW | Processor read descriptor or empty marker |
| irq_host | output | 1 | Level interrupt toward the host |
| irq_proc | output | 1 | Level interrupt toward the processor |
| align_err | output | 1 | Sticky misaligned posted request flag |
| ovf_flags | output | 5 | Sticky per-queue overflow flags |

## Verification
A host access and a processor access can fall in the same cycle, and both contend for the one storage port. The bench provokes this with directed cycles in which the host pushes a request while the processor tries to pop the same queue. It also runs a long random phase where both strobes are raised independently. A cycle-level reference model judges each collision: the host operation must take effect, the processor must see `p_ready` low, and no processor response may follow, so the processor's retry later observes the host's entry in order.

// File: rtl/msgq_pkg.sv
package msgq_pkg;
   localparam int NQ = 5;

   typedef enum logic [2:0] {
      Q_REQ   = 3'd0,
      Q_RPOST = 3'd1,
      Q_RFREE = 3'd2,
      Q_HFREE = 3'd3,
      Q_HPOST = 3'd4
   } qid_t;

   typedef enum logic [1:0] {
      S_REQ   = 2'd0,
      S_REPLY = 2'd1,
      S_HIPRI = 2'd2,
      S_NONE  = 2'd3
   } sel_t;

   typedef struct packed {
      logic push;
      logic pop;
      logic chk_align;
      qid_t q;
   } qop_t;
endpackage

// File: rtl/msgq_decode.sv
module msgq_decode
   import msgq_pkg::*;
(
   input  logic       host_side,
   input  logic       write,
   input  logic [1:0] sel,
   output qop_t       op
);
   always_comb begin
      op.push      = 1'b0;
      op.pop       = 1'b0;
      op.chk_align = 1'b0;
      op.q         = Q_REQ;
      if (host_side) begin
         case (sel)
            S_REQ: begin
               op.q         = Q_REQ;
               op.push      = write;
               op.chk_align = write;
            end
            S_REPLY: begin
               op.q    = write ? Q_RFREE : Q_RPOST;
               op.push = write;
               op.pop  = !write;
            end
            S_HIPRI: begin
               op.q         = write ? Q_HPOST : Q_HFREE;
               op.push      = write;
               op.pop       = !write;
               op.chk_align = write;
            end
            default: ;
         endcase
      end else begin
         case (sel)
            S_REQ: begin
               op.q   = Q_REQ;
               op.pop = !write;
            end
            S_REPLY: begin
               op.q    = write ? Q_RPOST : Q_RFREE;
               op.push = write;
               op.pop  = !write;
            end
            S_HIPRI: begin
               op.q    = write ? Q_HFREE : Q_HPOST;
               op.push = write;
               op.pop  = !write;
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/msgq_qctl.sv
module msgq_qctl #(
   parameter int DEPTH = 8,
   localparam int AW = $clog2(DEPTH),
   localparam int CW = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic          pop,
   output logic [AW-1:0] wr_ptr,
   output logic [AW-1:0] rd_ptr,
   output logic          full,
   output logic          empty
);
   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt    <= '0;
      end else begin
         if (push) wr_ptr <= wr_ptr + AW'(1);
         if (pop)  rd_ptr <= rd_ptr + AW'(1);
         cnt <= cnt + CW'(push) - CW'(pop);
      end
   end

   assign full  = (cnt == CW'(DEPTH));
   assign empty = (cnt == '0);
endmodule

// File: rtl/msgq_ram.sv
module msgq_ram #(
   parameter int DW    = 32,
   parameter int WORDS = 40,
   localparam int RAW = $clog2(WORDS)
) (
   input  logic           clk,
   input  logic           en,
   input  logic           we,
   input  logic [RAW-1:0] addr,
   input  logic [DW-1:0]  wdata,
   output logic [DW-1:0]  rdata
);
   logic [DW-1:0] mem [WORDS];

   always_ff @(posedge clk) begin
      if (en) begin
         if (we) mem[addr] <= wdata;
         else    rdata     <= mem[addr];
      end
   end
endmodule

// File: rtl/msgq_unit.sv
module msgq_unit
   import msgq_pkg::*;
#(
   parameter int DW         = 32,
   parameter int DEPTH      = 8,
   parameter int ALIGN_BITS = 7
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            h_valid,
   input  logic            h_write,
   input  logic [1:0]      h_sel,
   input  logic [DW-1:0]   h_wdata,
   output logic            h_ready,
   output logic            h_rvalid,
   output logic [DW-1:0]   h_rdata,
   input  logic            p_valid,
   input  logic            p_write,
   input  logic [1:0]      p_sel,
   input  logic [DW-1:0]   p_wdata,
   output logic            p_ready,
   output logic            p_rvalid,
   output logic [DW-1:0]   p_rdata,
   output logic            irq_host,
   output logic            irq_proc,
   output logic            align_err,
   output logic [NQ-1:0]   ovf_flags
);
   localparam int AW    = $clog2(DEPTH);
   localparam int WORDS = NQ * DEPTH;
   localparam int RAW   = $clog2(WORDS);

   if (DEPTH < 2 || (1 << AW) != DEPTH) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 2");
   end
   if (ALIGN_BITS < 0 || ALIGN_BITS >= DW) begin : g_bad_align
      $error("ALIGN_BITS must lie below DW");
   end

   // arbitration: host has fixed priority on the single storage port
   logic          acc, use_host, a_write;
   logic [1:0]    a_sel;
   logic [DW-1:0] a_wdata;
   qop_t          op;

   assign h_ready  = 1'b1;
   assign p_ready  = !h_valid;
   assign use_host = h_valid;
   assign acc      = h_valid | p_valid;
   assign a_write  = use_host ? h_write : p_write;
   assign a_sel    = use_host ? h_sel   : p_sel;
   assign a_wdata  = use_host ? h_wdata : p_wdata;

   msgq_decode u_dec (
      .host_side (use_host),
      .write     (a_write),
      .sel       (a_sel),
      .op        (op)
   );

   logic aligned;
   if (ALIGN_BITS > 0) begin : g_align
      assign aligned = (a_wdata[ALIGN_BITS-1:0] == '0);
   end else begin : g_noalign
      assign aligned = 1'b1;
   end

   logic [NQ-1:0] q_full, q_empty, push_v, pop_v;
   logic [AW-1:0] wr_ptr [NQ];
   logic [AW-1:0] rd_ptr [NQ];
   logic          push_req, bad_align, push_ok, pop_ok, ovf_hit, mark;

   assign push_req  = acc & op.push;
   assign bad_align = push_req & op.chk_align & !aligned;
   assign push_ok   = push_req & !bad_align & !q_full[op.q];
   assign ovf_hit   = push_req & !bad_align &  q_full[op.q];
   assign pop_ok    = acc & op.pop & !q_empty[op.q];
   assign mark      = acc & !a_write & !pop_ok;

   for (genvar i = 0; i < NQ; i++) begin : g_q
      assign push_v[i] = push_ok & (op.q == qid_t'(i));
      assign pop_v[i]  = pop_ok  & (op.q == qid_t'(i));
      msgq_qctl #(.DEPTH(DEPTH)) u_ctl (
         .clk    (clk),
         .rst_n  (rst_n),
         .push   (push_v[i]),
         .pop    (pop_v[i]),
         .wr_ptr (wr_ptr[i]),
         .rd_ptr (rd_ptr[i]),
         .full   (q_full[i]),
         .empty  (q_empty[i])
      );
   end

   // address into the shared array: region of the queue plus its pointer
   logic [AW-1:0]  sel_ptr;
   logic [RAW-1:0] ram_addr;
   logic [DW-1:0]  ram_rdata;

   always_comb begin
      sel_ptr = '0;
      for (int i = 0; i < NQ; i++) begin
         if (op.q == qid_t'(i)) sel_ptr = op.push ? wr_ptr[i] : rd_ptr[i];
      end
   end
   assign ram_addr = RAW'(32'(op.q) * DEPTH + 32'(sel_ptr));

   msgq_ram #(.DW(DW), .WORDS(WORDS)) u_ram (
      .clk   (clk),
      .en    (push_ok | pop_ok),
      .we    (push_ok),
      .addr  (ram_addr),
      .wdata (a_wdata),
      .rdata (ram_rdata)
   );

   // response and sticky flag registers
   logic h_rv_q, h_mk_q, p_rv_q, p_mk_q, align_q;
   logic [NQ-1:0] ovf_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         h_rv_q  <= 1'b0;
         h_mk_q  <= 1'b0;
         p_rv_q  <= 1'b0;
         p_mk_q  <= 1'b0;
         align_q <= 1'b0;
         ovf_q   <= '0;
      end else begin
         h_rv_q <= h_valid & !h_write;
         h_mk_q <= use_host & mark;
         p_rv_q <= p_valid & !h_valid & !p_write;
         p_mk_q <= !use_host & mark;
         if (bad_align) align_q <= 1'b1;
         for (int i = 0; i < NQ; i++) begin
            if (ovf_hit && op.q == qid_t'(i)) ovf_q[i] <= 1'b1;
         end
      end
   end

   assign h_rvalid  = h_rv_q;
   assign h_rdata   = !h_rv_q ? '0 : (h_mk_q ? '1 : ram_rdata);
   assign p_rvalid  = p_rv_q;
   assign p_rdata   = !p_rv_q ? '0 : (p_mk_q ? '1 : ram_rdata);
   assign align_err = align_q;
   assign ovf_flags = ovf_q;
   assign irq_host  = !q_empty[Q_RPOST];
   assign irq_proc  = !q_empty[Q_REQ] | !q_empty[Q_HPOST];
endmodule

// File: rtl/msgq_chk.sv
module msgq_chk #(
   parameter int NQ = 5,
   parameter int DW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          h_valid,
   input logic          h_write,
   input logic [1:0]    h_sel,
   input logic          h_rvalid,
   input logic [DW-1:0] h_rdata,
   input logic          p_valid,
   input logic          p_write,
   input logic          p_ready,
   input logic          p_rvalid,
   input logic          irq_host,
   input logic          align_err,
   input logic [NQ-1:0] ovf_flags
);
   a_r8_host_priority: assert property (@(posedge clk) disable iff (!rst_n)
      h_valid |-> !p_ready);

   a_r8_stalled_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (p_valid && !p_write && !p_ready) |=> !p_rvalid);

   a_r2_host_read_resp: assert property (@(posedge clk) disable iff (!rst_n)
      (h_valid && !h_write) |=> h_rvalid);

   a_r5_req_read_marker: assert property (@(posedge clk) disable iff (!rst_n)
      (h_valid && !h_write && h_sel == 2'd0) |=> (h_rdata == {DW{1'b1}}));

   a_r6_align_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      align_err |=> align_err);

   a_r9_irq_host_fall: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq_host) |-> $past(h_valid && !h_write && h_sel == 2'd1));

   for (genvar i = 0; i < NQ; i++) begin : g_ovf
      a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
         ovf_flags[i] |=> ovf_flags[i]);
   end
endmodule

bind msgq_unit msgq_chk #(.NQ(msgq_pkg::NQ), .DW(DW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .h_valid   (h_valid),
   .h_write   (h_write),
   .h_sel     (h_sel),
   .h_rvalid  (h_rvalid),
   .h_rdata   (h_rdata),
   .p_valid   (p_valid),
   .p_write   (p_write),
   .p_ready   (p_ready),
   .p_rvalid  (p_rvalid),
   .irq_host  (irq_host),
   .align_err (align_err),
   .ovf_flags (ovf_flags)
);

// File: tb/tb_msgq_unit.sv
`timescale 1ns/100ps
module tb_msgq_unit;
   localparam int DEPTH = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic h_valid = 0, h_write = 0, p_valid = 0, p_write = 0;
   logic [1:0] h_sel = 0, p_sel = 0;
   logic [31:0] h_wdata = 0, p_wdata = 0;
   logic h_ready, h_rvalid, p_ready, p_rvalid, irq_host, irq_proc, align_err;
   logic [31:0] h_rdata, p_rdata;
   logic [4:0] ovf_flags;

   always #2.5 clk = ~clk;

   msgq_unit #(.DW(32), .DEPTH(DEPTH), .ALIGN_BITS(7)) dut (.*);

   int n_chk = 0, n_fail = 0;

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
      end
   endtask

   // reference model
   logic [31:0] mq [5][$];
   bit        e_hrv, e_prv, e_align;
   logic [31:0] e_hd, e_pd;
   logic [4:0]  e_ovf;

   function automatic void map_op(input bit host, input bit wr, input logic [1:0] sel,
                                  output int q, output bit push, output bit pop, output bit chk);
      q = -1; push = 0; pop = 0; chk = 0;
      if (host) begin
         if (sel == 0 && wr) begin q = 0; push = 1; chk = 1; end
         if (sel == 1) begin q = wr ? 2 : 1; push = wr; pop = !wr; end
         if (sel == 2) begin q = wr ? 4 : 3; push = wr; pop = !wr; chk = wr; end
      end else begin
         if (sel == 0 && !wr) begin q = 0; pop = 1; end
         if (sel == 1) begin q = wr ? 1 : 2; push = wr; pop = !wr; end
         if (sel == 2) begin q = wr ? 3 : 4; push = wr; pop = !wr; end
      end
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 5; i++) mq[i].delete();
         e_hrv = 0; e_prv = 0; e_align = 0; e_ovf = '0; e_hd = 0; e_pd = 0;
      end else begin
         int q; bit push, pop, chk, host, wr; logic [31:0] d; logic [1:0] s;
         logic [31:0] rd;
         e_hrv = 0; e_prv = 0;
         if (h_valid || p_valid) begin
            host = h_valid;
            wr = host ? h_write : p_write;
            s  = host ? h_sel : p_sel;
            d  = host ? h_wdata : p_wdata;
            map_op(host, wr, s, q, push, pop, chk);
            rd = 32'hFFFF_FFFF;
            if (push) begin
               if (chk && d[6:0] != 0) e_align = 1;
               else if (mq[q].size() == DEPTH) e_ovf[q] = 1;
               else mq[q].push_back(d);
            end
            if (pop && mq[q].size() > 0) rd = mq[q].pop_front();
            if (!wr) begin
               if (host) begin e_hrv = 1; e_hd = rd; end
               else begin e_prv = 1; e_pd = rd; end
            end
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         check(h_rvalid == e_hrv, "R2 h_rvalid", 32'(h_rvalid), 32'(e_hrv));
         if (e_hrv) check(h_rdata == e_hd, e_hd == '1 ? "R5 host marker" : "R3/R4 host data", h_rdata, e_hd);
         check(p_rvalid == e_prv, "R8 p_rvalid", 32'(p_rvalid), 32'(e_prv));
         if (e_prv) check(p_rdata == e_pd, e_pd == '1 ? "R5 proc marker" : "R2 proc data", p_rdata, e_pd);
         check(p_ready == !h_valid, "R8 p_ready", 32'(p_ready), 32'(!h_valid));
         check(irq_host == (mq[1].size() != 0), "R9 irq_host", 32'(irq_host), 32'(mq[1].size() != 0));
         check(irq_proc == (mq[0].size() != 0 || mq[4].size() != 0), "R9 irq_proc",
               32'(irq_proc), 32'(mq[0].size() != 0 || mq[4].size() != 0));
         check(align_err == e_align, "R6 align_err", 32'(align_err), 32'(e_align));
         check(ovf_flags == e_ovf, "R7 ovf_flags", 32'(ovf_flags), 32'(e_ovf));
      end
   end

   task automatic cyc(input bit hv, input bit hw, input logic [1:0] hs, input logic [31:0] hd,
                      input bit pv, input bit pw, input logic [1:0] ps, input logic [31:0] pd);
      @(negedge clk); #0.5;
      h_valid = hv; h_write = hw; h_sel = hs; h_wdata = hd;
      p_valid = pv; p_write = pw; p_sel = ps; p_wdata = pd;
   endtask
   task automatic hw_(input logic [1:0] s, input logic [31:0] d); cyc(1,1,s,d,0,0,0,0); endtask
   task automatic hr_(input logic [1:0] s); cyc(1,0,s,0,0,0,0,0); endtask
   task automatic pw_(input logic [1:0] s, input logic [31:0] d); cyc(0,0,0,0,1,1,s,d); endtask
   task automatic pr_(input logic [1:0] s); cyc(0,0,0,0,1,0,s,0); endtask
   task automatic idle(); cyc(0,0,0,0,0,0,0,0); endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      // R1 reset state
      check(!irq_host && !irq_proc, "R1 irq reset", {30'd0, irq_host, irq_proc}, 0);
      check(!align_err && ovf_flags == 0, "R1 flags reset", {26'd0, align_err, ovf_flags}, 0);
      check(!h_rvalid && !p_rvalid && h_ready, "R1 response reset", {29'd0, h_rvalid, p_rvalid, h_ready}, 1);
      @(negedge clk); rst_n = 1;

      // R2 request path in order, then empty pop
      hw_(0, 32'h100); hw_(0, 32'h200); hw_(0, 32'h300);
      pr_(0); pr_(0); pr_(0); pr_(0); idle();
      // R3 reply post and reply free
      pw_(1, 32'hA80); pw_(1, 32'hB00); hr_(1); hr_(1); hr_(1);
      hw_(1, 32'h1000); hw_(1, 32'h1080); pr_(1); pr_(1); pr_(1); idle();
      // R4 high-priority free and post
      pw_(2, 32'h2000); hr_(2); hr_(2); hw_(2, 32'h2080); pr_(2); pr_(2); idle();
      // R5 host read of request select and unused select
      hr_(0); hr_(3); pr_(3); idle();
      // R6 misaligned posts
      hw_(0, 32'h104); idle();
      check(!irq_proc, "R6 misaligned not stored", 32'(irq_proc), 0);
      hw_(2, 32'h2001); hw_(1, 32'h3003); pr_(1); idle();
      // R7 fill request queue past depth
      for (int i = 0; i <= DEPTH; i++) hw_(0, 32'(i + 1) << 7);
      idle();
      for (int i = 0; i <= DEPTH; i++) pr_(0);
      idle();
      // R10 writes with no write function
      pw_(0, 32'h500); hw_(3, 32'h600); pw_(3, 32'h700); idle();
      check(!irq_proc && !irq_host, "R10 ignored writes", {30'd0, irq_proc, irq_host}, 0);
      pr_(0); idle();
      // R8 contention: host posts while processor tries to pop
      cyc(1,1,0,32'h4000, 1,0,0,0);
      cyc(1,1,0,32'h4080, 1,0,0,0);
      cyc(0,0,0,0, 1,0,0,0);
      cyc(1,0,1,0, 1,1,1,32'h4100);
      cyc(0,0,0,0, 1,0,0,0);
      idle();
      // random mix
      for (int i = 0; i < 3000; i++) begin
         logic [31:0] r1, r2;
         r1 = $urandom; r2 = $urandom;
         if (r1[31:29] != 0) r1[6:0] = 0;
         cyc(r1[0] & r1[1], r1[2], r1[4:3], r1, r2[0], r2[2], r2[4:3], {r2[31:7], 7'd0});
      end
      idle(); idle();
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end
endmodule